// File: doc/BRIEF.md
# Note Duration Counter

This block gives one sound channel a self-timed duration. The processor writes a byte whose upper five bits select an 8-bit preset from a fixed 32-entry table, and the count then steps down by one on each half-frame pulse from an external frame sequencer. A halt bit, which the channel shares with another of its functions, can freeze the count.

A per-channel enable bit, written separately, clears the count at once and refuses new presets while it stays low. The channel is audible only while the count is nonzero. An `active` output reports that condition, both to gate the waveform and for a status read-back.

The block sees decoded write strobes, data fields and the frame pulse only. Address decoding, waveform generation and the frame sequencer lie outside it.

Top module: `dur_counter_top`

## Requirements
- R1: After synchronous reset, `count` is 0, `active` is 0, the enable flag is clear (a load is ignored) and the halt flag is clear (a frame pulse decrements).
- R2: A load write takes its 5-bit index i from `load_byte[7:3]`. Bits 2..0 have no effect. The count becomes table[i], where the table is defined as follows. For odd i, the entry is 254 when i=1 and i-1 otherwise. For even i, let k=i[3:1] and base=10 when i[4]=0 or 12 when i[4]=1. The entry is then base<<k for k=0..4, base*6 for k=5, base+4 for k=6, and 26 (i[4]=0) or 32 (i[4]=1) for k=7.
- R3: While the enable flag is clear, a load write is ignored and the count stays 0.
- R4: An enable write with value 0 makes the count 0 on the next cycle, whatever its old value. This also holds when a load write arrives in the same cycle.
- R5: An enable write with value 1 leaves the count unchanged.
- R6: On a frame pulse with the halt flag clear, a nonzero count decreases by exactly one.
- R7: A frame pulse leaves a count of 0 at 0.
- R8: While the halt flag is set, frame pulses leave the count unchanged. A halt write takes effect from the cycle after the write.
- R9: When a load write and a frame pulse arrive in the same cycle, the count becomes the table value with no decrement.
- R10: `active` is 1 exactly when `count` is nonzero.
- R11: An enable write with value 1 and a load write in the same cycle load the table value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_we | input | 1 | Enable-bit write strobe |
| en_val | input | 1 | Enable value written |
| halt_we | input | 1 | Halt-bit write strobe |
| halt_val | input | 1 | Halt value written |
| load_we | input | 1 | Preset-load write strobe |
| load_byte | input | 8 | Written byte; bits 7..3 are the table index |
| frame_tick | input | 1 | Half-frame pulse from the sequencer |
| count | output | 8 | Current remaining duration |
| active | output | 1 | High while count is nonzero |

## Verification
The bench uses the default parameters: an 8-bit count, a 5-bit index and the index at bit 3. With these values all 32 table entries can be visited. Every preset is loaded with varied low bits and counted down pulse by pulse to zero and one pulse past it, so every count value the table can produce is checked against the arithmetic table rule. Directed sequences then cover same-cycle collisions of load, pulse, enable and halt writes.

// File: rtl/dur_pkg.sv
package dur_pkg;
    localparam int unsigned DUR_CNT_W = 8;
    localparam int unsigned DUR_IDX_W = 5;

    typedef struct packed {
        logic en;
        logic halt;
    } dur_flags_t;
endpackage

// File: rtl/dur_lut.sv
module dur_lut #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned CNT_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] preset
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [CNT_W-1:0] rom [ENTRIES];

    // Fixed preset table; entries beyond 32 (larger index widths) stay 0.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
            always_comb begin
                case (g)
                    0:  rom[g] = CNT_W'(10);
                    1:  rom[g] = CNT_W'(254);
                    2:  rom[g] = CNT_W'(20);
                    3:  rom[g] = CNT_W'(2);
                    4:  rom[g] = CNT_W'(40);
                    5:  rom[g] = CNT_W'(4);
                    6:  rom[g] = CNT_W'(80);
                    7:  rom[g] = CNT_W'(6);
                    8:  rom[g] = CNT_W'(160);
                    9:  rom[g] = CNT_W'(8);
                    10: rom[g] = CNT_W'(60);
                    11: rom[g] = CNT_W'(10);
                    12: rom[g] = CNT_W'(14);
                    13: rom[g] = CNT_W'(12);
                    14: rom[g] = CNT_W'(26);
                    15: rom[g] = CNT_W'(14);
                    16: rom[g] = CNT_W'(12);
                    17: rom[g] = CNT_W'(16);
                    18: rom[g] = CNT_W'(24);
                    19: rom[g] = CNT_W'(18);
                    20: rom[g] = CNT_W'(48);
                    21: rom[g] = CNT_W'(20);
                    22: rom[g] = CNT_W'(96);
                    23: rom[g] = CNT_W'(22);
                    24: rom[g] = CNT_W'(192);
                    25: rom[g] = CNT_W'(24);
                    26: rom[g] = CNT_W'(72);
                    27: rom[g] = CNT_W'(26);
                    28: rom[g] = CNT_W'(16);
                    29: rom[g] = CNT_W'(28);
                    30: rom[g] = CNT_W'(32);
                    31: rom[g] = CNT_W'(30);
                    default: rom[g] = '0;
                endcase
            end
        end
    endgenerate

    assign preset = rom[idx];
endmodule

// File: rtl/dur_flags.sv
module dur_flags
    import dur_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_we,
    input  logic en_val,
    input  logic halt_we,
    input  logic halt_val,
    output logic en_q,
    output logic en_eff,
    output logic halt_q
);
    dur_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (en_we)   flags_d.en   = en_val;
        if (halt_we) flags_d.halt = halt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign en_q   = flags_q.en;
    assign halt_q = flags_q.halt;
    // Enable as seen by the counter in this cycle, including a same-cycle write.
    assign en_eff = flags_d.en;
endmodule

// File: rtl/dur_count.sv
module dur_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_eff,
    input  logic             load_fire,
    input  logic [CNT_W-1:0] preset,
    input  logic             tick,
    input  logic             halt_q,
    output logic [CNT_W-1:0] cnt_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!en_eff) begin
            st_d.cnt = '0;
        end else if (load_fire) begin
            st_d.cnt = preset;
        end else if (tick && !halt_q && !at_zero) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/dur_counter_top.sv
module dur_counter_top #(
    parameter int unsigned CNT_W    = dur_pkg::DUR_CNT_W,
    parameter int unsigned IDX_W    = dur_pkg::DUR_IDX_W,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDX_LSB  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              en_val,
    input  logic              halt_we,
    input  logic              halt_val,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              frame_tick,
    output logic [CNT_W-1:0]  count,
    output logic              active
);
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    logic             en_q;
    logic             en_eff;
    logic             halt_q;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] preset;

    assign idx = load_byte[IDX_MSB:IDX_LSB];

    dur_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_val   (en_val),
        .halt_we  (halt_we),
        .halt_val (halt_val),
        .en_q     (en_q),
        .en_eff   (en_eff),
        .halt_q   (halt_q)
    );

    dur_lut #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_lut (
        .idx    (idx),
        .preset (preset)
    );

    dur_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en_eff    (en_eff),
        .load_fire (load_we),
        .preset    (preset),
        .tick      (frame_tick),
        .halt_q    (halt_q),
        .cnt_q     (count)
    );

    assign active = (count != '0);
endmodule

// File: rtl/dur_counter_chk.sv
module dur_counter_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_we,
    input logic             en_val,
    input logic             load_we,
    input logic             frame_tick,
    input logic             halt_q,
    input logic             en_q,
    input logic [CNT_W-1:0] count,
    input logic             active
);
    // R4
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en_we && !en_val) |=> (count == '0));

    // R3
    disabled_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (count == '0));

    // R8
    halt_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !load_we && !en_we) |=> $stable(count));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !halt_q && (count != '0) && !load_we && !en_we)
        |=> (count == $past(count) - CNT_W'(1)));

    // R7
    zero_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_we && (count == '0)) |=> (count == '0));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_we && !frame_tick && !(en_we && !en_val)) |=> $stable(count));

    // R10
    active_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        active == (count != '0));
endmodule

bind dur_counter_top dur_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_we      (en_we),
    .en_val     (en_val),
    .load_we    (load_we),
    .frame_tick (frame_tick),
    .halt_q     (halt_q),
    .en_q       (en_q),
    .count      (count),
    .active     (active)
);

// File: tb/sim_dur_counter_top.sv
`timescale 1ns/1ps
module sim_dur_counter_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_we = 1'b0, en_val = 1'b0;
    logic       halt_we = 1'b0, halt_val = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_byte = 8'h00;
    logic       frame_tick = 1'b0;
    logic [7:0] count;
    logic       active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dur_counter_top u0 (
        .clk(clk), .rst(rst), .en_we(en_we), .en_val(en_val),
        .halt_we(halt_we), .halt_val(halt_val), .load_we(load_we),
        .load_byte(load_byte), .frame_tick(frame_tick),
        .count(count), .active(active)
    );

    function automatic int exp_tab(input int i);
        int k;
        int base;
        if (i % 2 == 1) return (i == 1) ? 254 : i - 1;
        k    = (i >> 1) & 7;
        base = (i >= 16) ? 12 : 10;
        if (k <= 4) return base << k;
        if (k == 5) return base * 6;
        if (k == 6) return base + 4;
        return (i >= 16) ? 32 : 26;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input int exp);
        chk(req, count, exp);
        chk("R10", active, (exp != 0) ? 1 : 0);
    endtask

    // Apply strobes for one cycle; outputs are updated at the following negedge.
    task automatic step(input bit ew, input bit ev, input bit hw, input bit hv,
                        input bit lw, input logic [7:0] lb, input bit tk);
        en_we = ew; en_val = ev; halt_we = hw; halt_val = hv;
        load_we = lw; load_byte = lb; frame_tick = tk;
        @(negedge clk);
        en_we = 0; halt_we = 0; load_we = 0; frame_tick = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk_cnt("R1", 0);
        step(0,0,0,0,1,8'h08,0);            // load ignored: enable clear
        chk_cnt("R1", 0);

        // R2/R6/R7: sweep all indices, count each down fully
        for (int i = 0; i < 32; i++) begin
            int e;
            e = exp_tab(i);
            step(1,1,0,0,0,8'h00,0);
            step(0,0,0,0,1,{i[4:0], 3'(i ^ 5)},0);
            chk_cnt("R2", e);
            for (int n = e - 1; n >= 0; n--) begin
                step(0,0,0,0,0,8'h00,1);
                chk_cnt("R6", n);
            end
            step(0,0,0,0,0,8'h00,1);
            chk_cnt("R7", 0);
        end

        // R4: clear mid-count
        step(0,0,0,0,1,8'h08,0);             // idx1 -> 254
        step(0,0,0,0,0,8'h00,1);
        chk_cnt("R6", 253);
        step(1,0,0,0,0,8'h00,0);
        chk_cnt("R4", 0);
        // R3: load while disabled
        step(0,0,0,0,1,8'h40,0);
        chk_cnt("R3", 0);
        // R5: enable set has no effect
        step(1,1,0,0,0,8'h00,0);
        chk_cnt("R5", 0);
        step(0,0,0,0,1,8'h18,0);             // idx3 -> 2
        chk_cnt("R2", 2);
        step(1,1,0,0,0,8'h00,0);
        chk_cnt("R5", 2);

        // R8: halt set; same-cycle halt write does not yet stop the tick
        step(0,0,0,0,1,8'h20,0);             // idx4 -> 40
        step(0,0,1,1,0,8'h00,1);
        chk_cnt("R8", 39);
        step(0,0,0,0,0,8'h00,1);
        chk_cnt("R8", 39);
        step(0,0,0,0,0,8'h00,1);
        chk_cnt("R8", 39);
        step(0,0,1,0,0,8'h00,1);             // halt clear lands after this tick
        chk_cnt("R8", 39);
        step(0,0,0,0,0,8'h00,1);
        chk_cnt("R8", 38);

        // R9: load and tick together
        step(0,0,0,0,1,8'hC0,1);             // idx24 -> 192
        chk_cnt("R9", 192);
        // R4: clear with same-cycle load
        step(1,0,0,0,1,8'hC0,0);
        chk_cnt("R4", 0);
        // R11: enable set with same-cycle load
        step(1,1,0,0,1,8'hF8,0);             // idx31 -> 30
        chk_cnt("R11", 30);

        // R1: reset clears count, enable and halt
        step(0,0,1,1,0,8'h00,0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_cnt("R1", 0);
        step(0,0,0,0,1,8'h08,0);
        chk_cnt("R1", 0);
        step(1,1,0,0,1,8'h08,0);
        step(0,0,0,0,0,8'h00,1);
        chk_cnt("R1", 253);

        finish_run();
    end
endmodule